// File: doc/BRIEF.md
# External Bus Release Handshake Controller

This block decides who drives a processor's external bus: the CPU's own bus cycle engine or an outside bus master. The outside master pulls the active-low request line down. The controller passes that line through a synchronizer and samples it at a fixed point in each CPU access. It lets the access that is running finish, then lowers the active-low acknowledge and turns off the drivers for address, data and all strobes. It keeps watching the request for as long as the bus is released. When the request is withdrawn, it raises acknowledge and turns the drivers back on in the same cycle. It then holds off the next CPU access for one further cycle.

An optional active-low request-out line tells the outside master that the bus is given away. It is low while the bus is released and rises one and a half clocks after acknowledge rises. A single enable bit gates it. Every pin is a plain level signal. The block has no data path and no valid/ready interface, so no back-pressure applies.

Top module: `bus_release_ctrl`

## Requirements
- R1: While reset is held, and in the first cycle after it: ack_n=1, bus_oe=1, cpu_hold=0, reqo_n=1.
- R2: req_n passes through a two-flop synchronizer. The synchronized value is sampled only at a clock edge where cyc_t1=1 (the edge that opens the second state of an access) or where cyc_busy=0 (no access running). When req_n falls with the CPU idle, ack_n goes low after the fourth rising edge that follows.
- R3: After a low request has been sampled, ack_n falls at the first later rising edge at which cyc_last=1 or cyc_busy=0. It never falls in the middle of an access.
- R4: While ack_n=0, bus_oe=0, which tri-states the address, data, read, address and both write strobes. Otherwise bus_oe=1.
- R5: While the bus is released, the synchronized request is sampled at every edge. A sampled high level raises ack_n and bus_oe together at that edge. cpu_hold stays 1 for that one cycle and is 0 in the cycle after.
- R6: The released state lasts at least one clock cycle. This holds even for a request pulse that lasts only one cycle.
- R7: cpu_hold=1 from the edge at which a low request is sampled until the return cycle ends. The CPU must start no new access while cpu_hold=1.
- R8: With reqo_en=1, reqo_n=0 while ack_n=0. After ack_n rises, reqo_n rises at the falling clock edge that comes 1.5 clocks later.
- R9: With reqo_en=0, reqo_n=1 at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_n | input | 1 | Active-low bus request from the outside master; may be asynchronous |
| cyc_busy | input | 1 | A CPU bus access is in progress |
| cyc_t1 | input | 1 | The current state is the first state of the access |
| cyc_last | input | 1 | The current state is the final state of the access |
| reqo_en | input | 1 | Enables the request-out line |
| ack_n | output | 1 | Active-low bus acknowledge |
| bus_oe | output | 1 | Output enable for the address, data and strobe drivers |
| cpu_hold | output | 1 | Blocks the start of a new CPU access |
| reqo_n | output | 1 | Active-low request-out, gated by reqo_en |

## Verification
The bench goes after a request that arrives in the middle of a multi-state access. A design that granted the bus at once would drop acknowledge and tri-state the bus while the CPU still drives a strobe. A one-cycle request pulse checks that the release still lasts a full cycle and that the return cycle is not skipped, which would let the CPU collide with the departing master. Every half cycle the bench compares request-out against a model of the one-and-a-half-clock tail, so a delay of one or two clocks is caught. Phases with the enable off catch a request-out line that leaks through while disabled.

// File: rtl/brc_pkg.sv
package brc_pkg;
  typedef enum logic [1:0] {
    ST_OWNED     = 2'd0,
    ST_PENDING   = 2'd1,
    ST_RELEASED  = 2'd2,
    ST_RETURNING = 2'd3
  } brc_state_e;
endpackage

// File: rtl/brc_sync.sv
// Multi-stage synchronizer for the asynchronous request line; resets to the
// idle (high) level.
module brc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe <= '1;
    else        pipe <= {pipe[STAGES-2:0], d};
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/brc_fsm.sv
// Ownership state machine: CPU-owned, release pending, released, returning.
module brc_fsm
  import brc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_s,
  input  logic cyc_busy,
  input  logic cyc_t1,
  input  logic cyc_last,
  output logic ack_n,
  output logic bus_oe,
  output logic cpu_hold
);
  brc_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_OWNED:     if (!req_s && (cyc_t1 || !cyc_busy)) st_d = ST_PENDING;
      ST_PENDING:   if (cyc_last || !cyc_busy)           st_d = ST_RELEASED;
      ST_RELEASED:  if (req_s)                           st_d = ST_RETURNING;
      ST_RETURNING:                                      st_d = ST_OWNED;
      default:                                           st_d = ST_OWNED;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_OWNED;
    else        st_q <= st_d;
  end

  assign ack_n    = (st_q != ST_RELEASED);
  assign bus_oe   = (st_q != ST_RELEASED);
  assign cpu_hold = (st_q != ST_OWNED);
endmodule

// File: rtl/brc_reqo.sv
// Request-out tail: one rising-edge stage then one falling-edge stage, so the
// line releases 1.5 clocks after acknowledge returns high.
module brc_reqo (
  input  logic clk,
  input  logic rst_n,
  input  logic ack_n,
  input  logic reqo_en,
  output logic reqo_n
);
  logic rel_p;
  logic rel_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rel_p <= 1'b0;
    else        rel_p <= ~ack_n;
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) rel_n <= 1'b0;
    else        rel_n <= rel_p;
  end

  assign reqo_n = ~(reqo_en & (~ack_n | rel_p | rel_n));
endmodule

// File: rtl/bus_release_ctrl.sv
module bus_release_ctrl #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_n,
  input  logic cyc_busy,
  input  logic cyc_t1,
  input  logic cyc_last,
  input  logic reqo_en,
  output logic ack_n,
  output logic bus_oe,
  output logic cpu_hold,
  output logic reqo_n
);
  logic req_s;

  brc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(req_n), .q(req_s)
  );

  brc_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .req_s(req_s),
    .cyc_busy(cyc_busy), .cyc_t1(cyc_t1), .cyc_last(cyc_last),
    .ack_n(ack_n), .bus_oe(bus_oe), .cpu_hold(cpu_hold)
  );

  brc_reqo u_reqo (
    .clk(clk), .rst_n(rst_n), .ack_n(ack_n), .reqo_en(reqo_en), .reqo_n(reqo_n)
  );
endmodule

// File: rtl/brc_checker.sv
module brc_checker (
  input logic clk,
  input logic rst_n,
  input logic req_n,
  input logic cyc_busy,
  input logic cyc_t1,
  input logic cyc_last,
  input logic reqo_en,
  input logic ack_n,
  input logic bus_oe,
  input logic cpu_hold,
  input logic reqo_n
);
  // R4: drivers off and CPU blocked whenever the bus is granted away
  a_r4_released_tristate: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_n |-> (!bus_oe && cpu_hold));

  // R3: grant only at the end of an access or while idle
  a_r3_grant_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ack_n) |-> $past(cyc_last || !cyc_busy));

  // R7: the CPU was already held before the grant
  a_r7_hold_before_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ack_n) |-> $past(cpu_hold));

  // R5: drivers return with acknowledge; the CPU stays held for that cycle
  a_r5_drivers_back: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_n) |-> (bus_oe && cpu_hold));

  // R5: hold lasts exactly one return cycle
  a_r5_return_single: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_n) |=> !cpu_hold);

  // R8: request-out has not yet released when acknowledge rises
  a_r8_reqo_tail: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ack_n) && reqo_en) |-> !reqo_n);
endmodule

bind bus_release_ctrl brc_checker u_chk (.*);

// File: tb/bus_release_ctrl_tb.sv
module bus_release_ctrl_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_n = 1'b1;
  logic cyc_busy = 1'b0, cyc_t1 = 1'b0, cyc_last = 1'b0;
  logic reqo_en = 1'b1;
  logic ack_n, bus_oe, cpu_hold, reqo_n;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // reference model state
  int  m_st = 0;
  bit  m_s1 = 1, m_s2 = 1;
  bit  ah0 = 0, ah1 = 0, ah2 = 0;
  bit  run_model = 0;
  int  acc_left = 0;
  int  acc_len = 0;
  bit  cpu_gen_on = 1;

  always #10 clk = ~clk;

  bus_release_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .req_n(req_n), .cyc_busy(cyc_busy),
    .cyc_t1(cyc_t1), .cyc_last(cyc_last), .reqo_en(reqo_en),
    .ack_n(ack_n), .bus_oe(bus_oe), .cpu_hold(cpu_hold), .reqo_n(reqo_n)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic int next_st(int st, bit s2, bit busy, bit t1, bit last);
    case (st)
      0: return (!s2 && (t1 || !busy)) ? 1 : 0;
      1: return (last || !busy) ? 2 : 1;
      2: return s2 ? 3 : 2;
      default: return 0;
    endcase
  endfunction

  function automatic bit exp_reqo(bit en, bit a, bit b, bit c);
    return !(en && (a || b || c));
  endfunction

  // rising-edge model step and compare
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (run_model) begin
        m_st = next_st(m_st, m_s2, cyc_busy, cyc_t1, cyc_last);
        m_s2 = m_s1;
        m_s1 = req_n;
        ah2 = ah1; ah1 = ah0; ah0 = (m_st == 2);
        chk("R3 R5 R6", "ack_n", ack_n, m_st != 2);
        chk("R4", "bus_oe", bus_oe, m_st != 2);
        chk("R7", "cpu_hold", cpu_hold, m_st != 0);
        chk(reqo_en ? "R8" : "R9", "reqo_n", reqo_n, exp_reqo(reqo_en, ah0, ah1, ah2));
      end
    end
  end

  // falling-edge compare of the half-clock tail
  initial begin
    forever begin
      @(negedge clk);
      #5;
      if (run_model)
        chk(reqo_en ? "R8" : "R9", "reqo_n half", reqo_n, exp_reqo(reqo_en, ah0, ah1, 1'b0));
    end
  end

  // CPU access generator, driven at the falling edge
  task automatic cpu_step();
    if (acc_left > 0) acc_left--;
    else if (cpu_gen_on && !cpu_hold && ($urandom % 3 != 0)) begin
      acc_len = 2 + ($urandom % 2);
      acc_left = acc_len;
    end
    cyc_busy = (acc_left > 0);
    cyc_t1   = (acc_left > 0) && (acc_left == acc_len);
    cyc_last = (acc_left == 1);
  endtask

  task automatic negs(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cpu_step();
    end
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk("R1", "ack_n in reset", ack_n, 1'b1);
    chk("R1", "bus_oe in reset", bus_oe, 1'b1);
    chk("R1", "cpu_hold in reset", cpu_hold, 1'b0);
    chk("R1", "reqo_n in reset", reqo_n, 1'b1);
    rst_n = 1'b1;
    run_model = 1;

    // Directed: R2 request with CPU idle, grant after the fourth edge
    cpu_gen_on = 0;
    negs(2);
    @(negedge clk); req_n = 1'b0;
    repeat (3) @(posedge clk); #6;
    chk("R2", "ack_n after three edges", ack_n, 1'b1);
    @(posedge clk); #6;
    chk("R2", "ack_n after fourth edge", ack_n, 1'b0);
    @(negedge clk); req_n = 1'b1;
    repeat (3) @(posedge clk); #6;
    chk("R5", "ack_n back high", ack_n, 1'b1);
    chk("R5", "hold in return cycle", cpu_hold, 1'b1);
    @(posedge clk); #6;
    chk("R5", "hold cleared", cpu_hold, 1'b0);
    negs(4);

    // Directed: R6 one-cycle request pulse
    @(negedge clk); req_n = 1'b0;
    @(negedge clk); req_n = 1'b1;
    repeat (3) @(posedge clk); #6;
    chk("R6", "pulse granted", ack_n, 1'b0);
    @(posedge clk); #6;
    chk("R6", "pulse release ends", ack_n, 1'b1);
    negs(4);

    // Directed: R8 tail timing around the rise
    @(negedge clk); req_n = 1'b0;
    negs(6);
    @(negedge clk); req_n = 1'b1;
    @(posedge ack_n);
    @(posedge clk); #6;
    chk("R8", "reqo_n 1 clock after ack rise", reqo_n, 1'b0);
    @(negedge clk); #6;
    chk("R8", "reqo_n 1.5 clocks after ack rise", reqo_n, 1'b1);
    negs(3);

    // Random mix with CPU accesses
    cpu_gen_on = 1;
    for (int k = 0; k < 4000; k++) begin
      @(negedge clk);
      cpu_step();
      if ($urandom % 9 == 0) req_n = ~req_n;
      if (k % 700 == 350) reqo_en = 1'b0;
      if (k % 700 == 600) reqo_en = 1'b1;
    end

    // Directed: R9 disabled output during a release
    reqo_en = 1'b0;
    @(negedge clk); cpu_step(); req_n = 1'b0;
    negs(12);
    chk("R9", "reqo_n disabled while released", reqo_n, 1'b1);
    req_n = 1'b1;
    negs(8);
    chk("R9", "reqo_n disabled after release", reqo_n, 1'b1);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual running expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule